// File: doc/BRIEF.md
# Compressed Instruction Mode Sequencer

This block sits between instruction fetch and decode. It takes a stream of 16-bit halfwords and cuts it into instructions. Each instruction leaves with a tag that names its encoding: plain 32-bit, 10-bit compressed, 16-bit compressed, or the alternate 16-bit immediate format. The block keeps the current encoding mode as state. It updates that state from control bits that sit at the two ends of every compressed instruction. A side input from the 32-bit decoder moves the stream into compressed mode.

Bit positions in the halfword are numbered 0 for the most significant bit (`in_data[15]`) to 15 for the least significant bit (`in_data[0]`). The mode bit M is bit 15 (`in_data[0]`). The auxiliary bit N is bit 0 (`in_data[15]`). The block exposes the major opcode group held in bits 5..7 (`in_data[10:8]`). Full decoding is done downstream.

Both sides use valid/ready handshakes. An instruction moves when `out_valid && out_ready`. While the output is stalled, `in_ready` stays low and the halfword on `in_data` is not consumed. The mode state only changes on an accepted instruction, so back-pressure of any length leaves the mode sequence intact. In 32-bit mode the first halfword is taken at once (`in_ready` high) and is held inside the block. The output then offers the joined instruction while the second halfword is on `in_data`.

Top module: `cms_seq`

## Requirements
- R1: After reset the mode is 32-bit, no halfword is held, `in_ready` is high and `out_valid` stays low while the first halfword is offered.
- R2: In 32-bit mode two accepted halfwords form one instruction, with the first halfword in `out_insn[31:16]`. The instruction is tagged `out_mode`=0, and `out_group` and `out_illegal` are zero.
- R3: An accepted 32-bit instruction with `enter_cmp` high switches the next instruction to 10-bit mode (`out_mode`=1). Without `enter_cmp`, the stream stays in 32-bit mode.
- R4: After a 10-bit instruction, M=0 (`in_data[0]`=0) selects 32-bit mode and M=1 selects 16-bit mode (`out_mode`=2).
- R5: After a 16-bit instruction, {N,M}=01 keeps 16-bit mode and {N,M}=00 returns to 32-bit mode.
- R6: {N,M}=10 makes exactly one 32-bit instruction follow. The block then returns to 16-bit mode on its own, and `enter_cmp` on that one instruction has no effect.
- R7: {N,M}=11 tags the next instruction as the immediate format (`out_mode`=3). After an immediate-format instruction, {N,M} selects the next mode by the same rules as in 16-bit mode.
- R8: Every compressed instruction carries bits 5..7 (`in_data[10:8]`) on `out_group`.
- R9: `out_illegal` is high only for a 10-bit-mode instruction whose group is 001 and whose bits 0..3 (`in_data[15:12]`) are 1111.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low, the halfword is not consumed, and the mode does not change.
- R11: `flush` discards any held halfword and forces 32-bit mode. In the flush cycle `in_ready` and `out_valid` are low.
- R12: A compressed instruction is sent as one handshake per halfword. `out_insn[31:16]` is zero and `out_insn[15:0]` is the halfword.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop held halfword, force 32-bit mode |
| enter_cmp | input | 1 | Decoder request to enter compressed mode, sampled on an accepted 32-bit instruction |
| in_valid | input | 1 | Halfword valid |
| in_ready | output | 1 | Halfword accepted when high with in_valid |
| in_data | input | 16 | Halfword, bit 0 of the numbering is in_data[15] |
| out_valid | output | 1 | Instruction valid |
| out_ready | input | 1 | Downstream accepts instruction |
| out_insn | output | 32 | Instruction; compressed ones in the low half |
| out_mode | output | 2 | 0 32-bit, 1 10-bit, 2 16-bit, 3 immediate format |
| out_group | output | 3 | Major opcode group of a compressed instruction |
| out_illegal | output | 1 | Instruction unavailable in 10-bit mode |

## Verification
Two events can need the mode state in the same cycle: the close of a one-instruction excursion and an `enter_cmp` request on that same 32-bit instruction. The bench provokes this by raising `enter_cmp` while the excursion's second halfword is accepted. It then checks that the next halfword comes out tagged 16-bit rather than 10-bit. A second collision, a stalled output held for several cycles before it is released, is checked by confirming that the mode advances exactly once.

// File: rtl/cms_pkg.sv
package cms_pkg;
  typedef enum logic [1:0] {
    MD_STD = 2'd0,
    MD_C10 = 2'd1,
    MD_C16 = 2'd2,
    MD_IMM = 2'd3
  } mode_e;
endpackage

// File: rtl/cms_halfword_buf.sv
// Holds the upper halfword of a 32-bit instruction until its partner arrives.
module cms_halfword_buf #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic              clear,
  input  logic [HALF_W-1:0] in_data,
  output logic              held_valid,
  output logic [HALF_W-1:0] held_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      held_data  <= '0;
    end else if (flush) begin
      held_valid <= 1'b0;
    end else if (load) begin
      held_valid <= 1'b1;
      held_data  <= in_data;
    end else if (clear) begin
      held_valid <= 1'b0;
    end
  end

  // R2: a held upper halfword survives until its instruction leaves
  a_r2_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
    held_valid && !load && !clear && !flush |=> held_valid && $stable(held_data));
  // R11: flush drops the held halfword
  a_r11_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !held_valid);
endmodule

// File: rtl/cms_mode_fsm.sv
// Mode state: advances once per accepted instruction.
module cms_mode_fsm
  import cms_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush,
  input  logic  fire,
  input  logic  ctl_n,
  input  logic  ctl_m,
  input  logic  enter_cmp,
  output mode_e mode,
  output logic  excursion
);
  mode_e mode_nx;
  logic  exc_nx;

  always_comb begin
    mode_nx = mode;
    exc_nx  = excursion;
    unique case (mode)
      MD_STD: begin
        if (excursion) begin
          mode_nx = MD_C16;
          exc_nx  = 1'b0;
        end else if (enter_cmp) begin
          mode_nx = MD_C10;
        end
      end
      MD_C10: mode_nx = ctl_m ? MD_C16 : MD_STD;
      default: begin
        unique case ({ctl_n, ctl_m})
          2'b01: mode_nx = MD_C16;
          2'b00: mode_nx = MD_STD;
          2'b10: begin
            mode_nx = MD_STD;
            exc_nx  = 1'b1;
          end
          default: mode_nx = MD_IMM;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= MD_STD;
      excursion <= 1'b0;
    end else if (flush) begin
      mode      <= MD_STD;
      excursion <= 1'b0;
    end else if (fire) begin
      mode      <= mode_nx;
      excursion <= exc_nx;
    end
  end

  // R10: no accepted instruction, no mode change
  a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fire && !flush |=> $stable(mode) && $stable(excursion));
  // R11: flush forces 32-bit mode
  a_r11_flush_std: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> mode == MD_STD && !excursion);
  // R6: closing an excursion returns to 16-bit mode whatever enter_cmp says
  a_r6_exc_return: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !flush && mode == MD_STD && excursion |=> mode == MD_C16 && !excursion);
  // R3: entry request on a plain 32-bit instruction
  a_r3_entry: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !flush && mode == MD_STD && !excursion && enter_cmp |=> mode == MD_C10);
  // R6: excursion flag only lives in 32-bit mode
  a_r6_exc_in_std: assert property (@(posedge clk) disable iff (!rst_n)
    excursion |-> mode == MD_STD);
endmodule

// File: rtl/cms_field_tap.sv
// Pulls control bits, opcode group and legality out of a compressed halfword.
module cms_field_tap
  import cms_pkg::*;
#(
  parameter int              HALF_W     = 16,
  parameter int              GRP_W      = 3,
  parameter int              GRP_POS    = 5,
  parameter int              LEAD_W     = 4,
  parameter logic [GRP_W-1:0] RESTR_GRP = 3'b001,
  parameter bit              CHECK_C10  = 1'b1
) (
  input  logic [HALF_W-1:0] half,
  input  mode_e             mode,
  output logic              ctl_n,
  output logic              ctl_m,
  output logic [GRP_W-1:0]  group,
  output logic              illegal
);
  localparam int GRP_HI = HALF_W - 1 - GRP_POS;
  localparam int GRP_LO = GRP_HI - GRP_W + 1;

  logic [LEAD_W-1:0] lead;

  assign ctl_n = half[HALF_W-1];
  assign ctl_m = half[0];
  assign group = half[GRP_HI:GRP_LO];
  assign lead  = half[HALF_W-1 -: LEAD_W];

  generate
    if (CHECK_C10) begin : g_chk
      assign illegal = (mode == MD_C10) && (group == RESTR_GRP) &&
                       (lead == {LEAD_W{1'b1}});
    end else begin : g_nochk
      assign illegal = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cms_seq.sv
module cms_seq
  import cms_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int GRP_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                enter_cmp,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [HALF_W-1:0]   in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [2*HALF_W-1:0] out_insn,
  output logic [1:0]          out_mode,
  output logic [GRP_W-1:0]    out_group,
  output logic                out_illegal
);
  localparam int INSN_W = 2 * HALF_W;

  mode_e             mode;
  logic              excursion;
  logic              held_valid;
  logic [HALF_W-1:0] held_data;
  logic              is_std, fire, load, clear;
  logic              ctl_n, ctl_m, illegal;
  logic [GRP_W-1:0]  group;

  assign is_std = (mode == MD_STD);

  always_comb begin
    if (flush) begin
      in_ready  = 1'b0;
      out_valid = 1'b0;
    end else if (is_std && !held_valid) begin
      in_ready  = 1'b1;
      out_valid = 1'b0;
    end else begin
      in_ready  = out_ready;
      out_valid = in_valid;
    end
  end

  assign fire  = out_valid && out_ready;
  assign load  = !flush && is_std && !held_valid && in_valid;
  assign clear = fire && is_std;

  cms_halfword_buf #(.HALF_W(HALF_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(flush), .load(load), .clear(clear),
    .in_data(in_data), .held_valid(held_valid), .held_data(held_data)
  );

  cms_field_tap #(.HALF_W(HALF_W), .GRP_W(GRP_W)) u_tap (
    .half(in_data), .mode(mode), .ctl_n(ctl_n), .ctl_m(ctl_m),
    .group(group), .illegal(illegal)
  );

  cms_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fire(fire),
    .ctl_n(ctl_n), .ctl_m(ctl_m), .enter_cmp(enter_cmp),
    .mode(mode), .excursion(excursion)
  );

  assign out_insn    = is_std ? {held_data, in_data} : {{(INSN_W-HALF_W){1'b0}}, in_data};
  assign out_mode    = mode;
  assign out_group   = is_std ? '0 : group;
  assign out_illegal = !is_std && illegal;

  // R10: a stalled output keeps its mode tag
  a_r10_stall_mode: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !flush |=> $stable(out_mode));
  // R12: compressed instructions occupy only the low half
  a_r12_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mode != 2'd0 |-> out_insn[INSN_W-1:HALF_W] == '0);
  // R9: illegal flag only in 10-bit mode
  a_r9_illegal_mode: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_mode == 2'd1);
  // R2: 32-bit instructions carry no group
  a_r2_std_nogroup: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mode == 2'd0 |-> out_group == '0 && !out_illegal);
endmodule

// File: tb/cms_seq_tb.sv
module cms_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        enter_cmp = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_insn;
  logic [1:0]  out_mode;
  logic [2:0]  out_group;
  logic        out_illegal;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cms_seq u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .enter_cmp(enter_cmp),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn),
    .out_mode(out_mode), .out_group(out_group), .out_illegal(out_illegal)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // halfword: N at [15], group at [10:8], M at [0]
  function automatic logic [15:0] mk(input bit n, input logic [2:0] grp, input bit m);
    return {n, 4'b0110, grp, 7'b1010011, m};
  endfunction

  task automatic push(input logic [15:0] h, input bit en, input bit exp_ov,
                      input logic [31:0] exp_insn, input logic [1:0] exp_mode,
                      input logic [2:0] exp_grp, input bit exp_ill, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_data = h; enter_cmp = en; out_ready = 1'b1;
    #1;
    chk(req, "out_valid", 32'(out_valid), 32'(exp_ov));
    if (exp_ov) begin
      chk(req, "out_insn", out_insn, exp_insn);
      chk(req, "out_mode", 32'(out_mode), 32'(exp_mode));
      chk(req, "out_group", 32'(out_group), 32'(exp_grp));
      chk(req, "out_illegal", 32'(out_illegal), 32'(exp_ill));
    end
    @(posedge clk); #1;
    in_valid = 1'b0; enter_cmp = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1; in_valid = 1'b0;
    @(posedge clk); #1;
    flush = 1'b0;
  endtask

  // leaves the block in 16-bit mode
  task automatic go_c16();
    do_flush();
    push(16'h1111, 1'b0, 1'b0, 0, 0, 0, 0, "R3");
    push(16'h2222, 1'b1, 1'b1, 32'h11112222, 2'd0, 3'd0, 1'b0, "R3");
    push(mk(0, 3'b010, 1), 1'b0, 1'b1, {16'h0, mk(0, 3'b010, 1)}, 2'd1, 3'b010, 1'b0, "R4");
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "in_ready", 32'(in_ready), 32'd1);
    chk("R1", "out_valid idle", 32'(out_valid), 32'd0);
    push(16'hABCD, 1'b0, 1'b0, 0, 0, 0, 0, "R1");
  endtask

  task automatic t_std();
    push(16'h1234, 1'b0, 1'b1, 32'hABCD1234, 2'd0, 3'd0, 1'b0, "R2");
    push(16'hFFFF, 1'b0, 1'b0, 0, 0, 0, 0, "R2");
    push(16'h0001, 1'b0, 1'b1, 32'hFFFF0001, 2'd0, 3'd0, 1'b0, "R2");
    // no entry request: stays 32-bit
    push(16'h5555, 1'b0, 1'b0, 0, 0, 0, 0, "R3");
  endtask

  task automatic t_enter_c10();
    do_flush();
    push(16'h0A0A, 1'b0, 1'b0, 0, 0, 0, 0, "R3");
    push(16'hB0B0, 1'b1, 1'b1, 32'h0A0AB0B0, 2'd0, 3'd0, 1'b0, "R3");
    push(mk(1, 3'b100, 0), 1'b0, 1'b1, {16'h0, mk(1, 3'b100, 0)}, 2'd1, 3'b100, 1'b0, "R8");
    // M=0 -> back to 32-bit: next halfword is an upper half
    push(16'h7777, 1'b0, 1'b0, 0, 0, 0, 0, "R4");
    push(16'h8888, 1'b1, 1'b1, 32'h77778888, 2'd0, 3'd0, 1'b0, "R4");
    push(mk(0, 3'b111, 1), 1'b0, 1'b1, {16'h0, mk(0, 3'b111, 1)}, 2'd1, 3'b111, 1'b0, "R8");
    push(mk(0, 3'b110, 1), 1'b0, 1'b1, {16'h0, mk(0, 3'b110, 1)}, 2'd2, 3'b110, 1'b0, "R4");
  endtask

  task automatic t_c16();
    go_c16();
    push(mk(0, 3'b000, 1), 1'b0, 1'b1, {16'h0, mk(0, 3'b000, 1)}, 2'd2, 3'b000, 1'b0, "R5");
    push(mk(0, 3'b101, 0), 1'b0, 1'b1, {16'h0, mk(0, 3'b101, 0)}, 2'd2, 3'b101, 1'b0, "R5");
    push(16'hC0DE, 1'b0, 1'b0, 0, 0, 0, 0, "R5");
    push(16'hBEEF, 1'b0, 1'b1, 32'hC0DEBEEF, 2'd0, 3'd0, 1'b0, "R5");
  endtask

  task automatic t_excursion();
    go_c16();
    push(mk(1, 3'b011, 0), 1'b0, 1'b1, {16'h0, mk(1, 3'b011, 0)}, 2'd2, 3'b011, 1'b0, "R6");
    push(16'h1357, 1'b0, 1'b0, 0, 0, 0, 0, "R6");
    // enter_cmp raised on the closing instruction: must be ignored
    push(16'h2468, 1'b1, 1'b1, 32'h13572468, 2'd0, 3'd0, 1'b0, "R6");
    push(mk(0, 3'b010, 1), 1'b0, 1'b1, {16'h0, mk(0, 3'b010, 1)}, 2'd2, 3'b010, 1'b0, "R6");
  endtask

  task automatic t_imm();
    go_c16();
    push(mk(1, 3'b000, 1), 1'b0, 1'b1, {16'h0, mk(1, 3'b000, 1)}, 2'd2, 3'b000, 1'b0, "R7");
    push(mk(1, 3'b010, 1), 1'b0, 1'b1, {16'h0, mk(1, 3'b010, 1)}, 2'd3, 3'b010, 1'b0, "R7");
    push(mk(0, 3'b100, 1), 1'b0, 1'b1, {16'h0, mk(0, 3'b100, 1)}, 2'd3, 3'b100, 1'b0, "R7");
    push(mk(1, 3'b000, 0), 1'b0, 1'b1, {16'h0, mk(1, 3'b000, 0)}, 2'd2, 3'b000, 1'b0, "R7");
    // IMM {N,M}=10 excursion then back to 16-bit
    push(16'h4444, 1'b0, 1'b0, 0, 0, 0, 0, "R7");
    push(16'h5555, 1'b0, 1'b1, 32'h44445555, 2'd0, 3'd0, 1'b0, "R7");
  endtask

  task automatic t_illegal();
    logic [15:0] bad;
    bad = {4'b1111, 1'b0, 3'b001, 7'b0000000, 1'b1};
    do_flush();
    push(16'h9999, 1'b0, 1'b0, 0, 0, 0, 0, "R9");
    push(16'hAAAA, 1'b1, 1'b1, 32'h9999AAAA, 2'd0, 3'd0, 1'b0, "R9");
    push(bad, 1'b0, 1'b1, {16'h0, bad}, 2'd1, 3'b001, 1'b1, "R9");
    // same pattern in 16-bit mode is allowed
    push(bad, 1'b0, 1'b1, {16'h0, bad}, 2'd2, 3'b001, 1'b0, "R9");
  endtask

  task automatic t_backpressure();
    logic [15:0] h;
    h = mk(1, 3'b110, 1);
    go_c16();
    @(negedge clk);
    in_valid = 1'b1; in_data = h; out_ready = 1'b0;
    #1;
    chk("R10", "in_ready stalled", 32'(in_ready), 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R10", "out_valid stalled", 32'(out_valid), 32'd1);
    chk("R10", "mode stalled", 32'(out_mode), 32'd2);
    chk("R10", "insn stalled", out_insn, {16'h0, h});
    out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    // exactly one advance: immediate format next
    push(mk(0, 3'b000, 1), 1'b0, 1'b1, {16'h0, mk(0, 3'b000, 1)}, 2'd3, 3'b000, 1'b0, "R10");
    // 32-bit stall on the second halfword
    push(mk(0, 3'b000, 0), 1'b0, 1'b1, {16'h0, mk(0, 3'b000, 0)}, 2'd2, 3'b000, 1'b0, "R10");
    push(16'h6161, 1'b0, 1'b0, 0, 0, 0, 0, "R10");
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'h7272; out_ready = 1'b0;
    #1;
    chk("R10", "in_ready second half", 32'(in_ready), 32'd0);
    @(posedge clk); @(negedge clk);
    out_ready = 1'b1; #1;
    chk("R10", "insn after stall", out_insn, 32'h61617272);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic t_flush();
    do_flush();
    push(16'hDEAD, 1'b0, 1'b0, 0, 0, 0, 0, "R11");
    @(negedge clk);
    flush = 1'b1; in_valid = 1'b1; in_data = 16'h0F0F;
    #1;
    chk("R11", "in_ready in flush", 32'(in_ready), 32'd0);
    chk("R11", "out_valid in flush", 32'(out_valid), 32'd0);
    @(posedge clk); #1;
    flush = 1'b0; in_valid = 1'b0;
    push(16'h3030, 1'b0, 1'b0, 0, 0, 0, 0, "R11");
    push(16'h4040, 1'b0, 1'b1, 32'h30304040, 2'd0, 3'd0, 1'b0, "R11");
    go_c16();
    do_flush();
    push(16'h5050, 1'b0, 1'b0, 0, 0, 0, 0, "R11");
    push(16'h6060, 1'b0, 1'b1, 32'h50506060, 2'd0, 3'd0, 1'b0, "R11");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_std();
    t_enter_c10();
    t_c16();
    t_excursion();
    t_imm();
    t_illegal();
    t_backpressure();
    t_flush();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule